// File: doc/BRIEF.md
# Outbound Message Descriptor-Chaining Engine

This block takes transmit work from a circular ring of 32-byte descriptors in memory. Software sets up the ring by writing its base into the dequeue and enqueue pointer registers, choosing a ring size and setting the enable bit. After it writes each descriptor to memory, software sets a self-clearing advance bit in the mode register, which moves the enqueue pointer forward by one slot. While the two pointers differ and the unit is enabled, the engine reads the useful words of the descriptor at the dequeue pointer through a single-word read port. It then offers the destination ID, mailbox, source address and transfer size on a valid/ready request, and moves the dequeue pointer on by one slot.

Status comes back as sticky write-one-to-clear bits, as live busy and full bits, and as one interrupt line. A descriptor whose transfer count is not a power of two is reported as a transfer error and skipped. When the enable bit is cleared, the engine stops at the next descriptor boundary. The pointers keep their values, so setting the enable bit again continues from the same place.

Top module: `omsg_chain_engine`

## Requirements
- R1: After reset the mode register, status register and both pointers read 0, and `irq`, `tx_valid` and `mem_rd_en` are low.
- R2: A register write to the mode register (index 0) with bit 1 set moves the enqueue pointer (index 3) forward by 32. Once it passes the last slot it returns to the ring base. Bit 1 always reads back as 0.
- R3: When an advance would make the enqueue pointer equal to the dequeue pointer, the enqueue pointer does not change and status bit 5 (overflow) is set. Status bit 4 reads 1 whenever the ring is full in this sense.
- R4: Mode bits 15:12 hold a code n in the range 0 to 10, and the ring then holds 2^(n+1) slots. For example, code 0 gives a ring of two slots that can hold one pending descriptor.
- R5: When the unit is enabled and the pointers differ, the engine reads descriptor words 1, 2, 3 and 6, in that order, at byte addresses dequeue+4, +8, +12 and +24. It has only one read outstanding at a time.
- R6: The transmit request carries the destination ID from word 2 bits 31:16, the mailbox from word 2 bits 1:0, the source address from word 1 and the size from word 6. These values stay stable while `tx_valid` is high and `tx_ready` is low.
- R7: After each descriptor the dequeue pointer (index 2) moves forward by 32, returning to the base after the last slot. The slot register (index 4) reads (dequeue minus base) shifted right by 5.
- R8: Status bit 1 (end of message) is set after a descriptor is sent only when bit 29 of that descriptor's word 3 is set.
- R9: A word 6 count that is zero or not a power of two sets status bit 7 (transfer error). The engine issues no request for that descriptor and still advances the dequeue pointer.
- R10: When the unit is enabled and the ring is empty, the engine stays idle and sets status bit 0 (queue empty). Status bit 2 reads 1 while a descriptor is being processed.
- R11: When the enable bit (mode bit 0) is cleared, the current descriptor completes and no further descriptor starts. Both pointers keep their values.
- R12: Writing 1 to status bit 7, 5, 1 or 0 clears that bit. `irq` is the OR of bits 7, 5 and 1.
- R13: A write to the dequeue pointer register also loads the ring base, so the slot register then reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index: 0 mode, 1 status, 2 dequeue, 3 enqueue, 4 slot |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| mem_rd_en | output | 1 | Descriptor word read request |
| mem_rd_addr | output | 32 | Byte address of the requested word |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Read data |
| tx_valid | output | 1 | Transmit request valid |
| tx_ready | input | 1 | Transmit request accepted |
| tx_dest_id | output | 16 | Destination ID |
| tx_mbox | output | 2 | Mailbox number |
| tx_src_addr | output | 32 | Source buffer address |
| tx_size | output | 32 | Message length in bytes |
| irq | output | 1 | Interrupt (error, overflow or end of message) |

## Verification
The assertions assume that software loads the pointer registers only while the engine is idle, and never sets the advance bit in the same cycle that it loads the enqueue pointer. They also assume that the read port returns exactly one data beat for each request and never returns a beat without a request. The stimulus follows these rules: pointer loads happen only after the ring has drained or while the unit is disabled, each register write uses its own cycle, and the memory model returns data one cycle after each request it sees. The ring base is aligned, and the descriptor contents are chosen so that every legal and illegal count case is visited.

// File: rtl/omsg_pkg.sv
package omsg_pkg;
    parameter int unsigned AW = 32;
    parameter int unsigned DW = 32;

    localparam int unsigned DESC_BYTES = 32;
    localparam int unsigned DESC_SHIFT = 5;
    localparam int unsigned CODE_W     = 4;
    localparam int unsigned CODE_MAX   = 10;
    localparam int unsigned SLOT_W     = CODE_MAX + 1;

    localparam logic [2:0] RA_MODE = 3'd0;
    localparam logic [2:0] RA_STAT = 3'd1;
    localparam logic [2:0] RA_DEQ  = 3'd2;
    localparam logic [2:0] RA_ENQ  = 3'd3;
    localparam logic [2:0] RA_SLOT = 3'd4;

    localparam int MB_EN   = 0;
    localparam int MB_ADV  = 1;
    localparam int MB_CODE = 12;

    localparam int SB_ERR   = 7;
    localparam int SB_OVF   = 5;
    localparam int SB_FULL  = 4;
    localparam int SB_BUSY  = 2;
    localparam int SB_EOM   = 1;
    localparam int SB_EMPTY = 0;

    localparam int ATTR_EOM = 29;

    typedef enum logic [2:0] {
        ST_IDLE, ST_REQ, ST_WAIT, ST_CHECK, ST_SEND, ST_DONE
    } fetch_state_t;

    typedef struct packed {
        logic [15:0]   dest;
        logic [1:0]    mbox;
        logic          eom_en;
        logic [AW-1:0] src;
        logic [DW-1:0] count;
    } desc_t;

    // descriptor word fetched at step k of the fetch sequence
    function automatic logic [2:0] word_index(input logic [1:0] k);
        case (k)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            2'd2:    return 3'd3;
            default: return 3'd6;
        endcase
    endfunction

    function automatic logic is_pow2(input logic [DW-1:0] v);
        return (v != '0) && ((v & (v - 1'b1)) == '0);
    endfunction

    function automatic logic [AW-1:0] ring_bytes(input logic [CODE_W-1:0] code);
        logic [CODE_W-1:0] c;
        c = (code > CODE_W'(CODE_MAX)) ? CODE_W'(CODE_MAX) : code;
        return AW'(DESC_BYTES) << (c + 1'b1);
    endfunction

    function automatic logic [AW-1:0] ring_next(input logic [AW-1:0] ptr,
                                                input logic [AW-1:0] base,
                                                input logic [AW-1:0] bytes);
        logic [AW-1:0] nxt;
        nxt = ptr + AW'(DESC_BYTES);
        return (nxt == base + bytes) ? base : nxt;
    endfunction
endpackage

// File: rtl/omsg_ring_ptrs.sv
module omsg_ring_ptrs
    import omsg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] size_code,
    input  logic              deq_load,
    input  logic              enq_load,
    input  logic [AW-1:0]     load_val,
    input  logic              adv_req,
    input  logic              deq_step,
    output logic [AW-1:0]     deq_ptr,
    output logic [AW-1:0]     enq_ptr,
    output logic              empty,
    output logic              full,
    output logic              ovf_evt,
    output logic [SLOT_W-1:0] slot_idx
);
    logic [AW-1:0] ring_base;
    logic [AW-1:0] bytes;
    logic [AW-1:0] enq_nxt;
    logic [AW-1:0] deq_nxt;
    logic [AW-1:0] offset;

    always_comb begin
        bytes    = ring_bytes(size_code);
        enq_nxt  = ring_next(enq_ptr, ring_base, bytes);
        deq_nxt  = ring_next(deq_ptr, ring_base, bytes);
        empty    = (deq_ptr == enq_ptr);
        full     = (enq_nxt == deq_ptr);
        ovf_evt  = adv_req && full;
        offset   = deq_ptr - ring_base;
        slot_idx = offset[DESC_SHIFT +: SLOT_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            deq_ptr   <= '0;
            enq_ptr   <= '0;
            ring_base <= '0;
        end else begin
            if (deq_load) begin
                deq_ptr   <= load_val;
                ring_base <= load_val;
            end else if (deq_step) begin
                deq_ptr <= deq_nxt;
            end
            if (enq_load) begin
                enq_ptr <= load_val;
            end else if (adv_req && !full) begin
                enq_ptr <= enq_nxt;
            end
        end
    end

    // R3: a rejected advance leaves the enqueue pointer where it was
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (adv_req && full && !enq_load) |=> (enq_ptr == $past(enq_ptr)));

    // R7: dequeue steps by one slot or wraps to the base
    p_deq_step_r7: assert property (@(posedge clk) disable iff (rst)
        (deq_step && !deq_load) |=>
            ((deq_ptr == $past(deq_ptr) + AW'(DESC_BYTES)) || (deq_ptr == ring_base)));
endmodule

// File: rtl/omsg_desc_fetch.sv
module omsg_desc_fetch
    import omsg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          empty,
    input  logic [AW-1:0] deq_ptr,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rd_valid,
    input  logic [DW-1:0] mem_rd_data,
    output logic          tx_valid,
    input  logic          tx_ready,
    output desc_t         tx_desc,
    output logic          deq_step,
    output logic          eom_evt,
    output logic          err_evt,
    output logic          busy
);
    fetch_state_t st;
    logic [1:0]   k;
    desc_t        d;
    logic         bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            k   <= '0;
            d   <= '0;
            bad <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (en && !empty) begin
                    st  <= ST_REQ;
                    k   <= '0;
                    bad <= 1'b0;
                end
                ST_REQ: st <= ST_WAIT;
                ST_WAIT: if (mem_rd_valid) begin
                    case (k)
                        2'd0: d.src <= mem_rd_data;
                        2'd1: begin
                            d.dest <= mem_rd_data[31:16];
                            d.mbox <= mem_rd_data[1:0];
                        end
                        2'd2: d.eom_en <= mem_rd_data[ATTR_EOM];
                        default: d.count <= mem_rd_data;
                    endcase
                    if (k == 2'd3) begin
                        st <= ST_CHECK;
                    end else begin
                        k  <= k + 1'b1;
                        st <= ST_REQ;
                    end
                end
                ST_CHECK: if (is_pow2(d.count)) begin
                    st <= ST_SEND;
                end else begin
                    bad <= 1'b1;
                    st  <= ST_DONE;
                end
                ST_SEND: if (tx_ready) st <= ST_DONE;
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_rd_en   = (st == ST_REQ);
        mem_rd_addr = deq_ptr + AW'({word_index(k), 2'b00});
        tx_valid    = (st == ST_SEND);
        tx_desc     = d;
        deq_step    = (st == ST_DONE);
        eom_evt     = (st == ST_DONE) && !bad && d.eom_en;
        err_evt     = (st == ST_CHECK) && !is_pow2(d.count);
        busy        = (st != ST_IDLE);
    end

    // R6: request contents hold while waiting for ready
    p_tx_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_desc)));

    // R5: never two read requests back to back
    p_single_read_r5: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en);

    // R10: an idle engine facing an empty ring issues no read
    p_idle_empty_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && empty) |=> !mem_rd_en);
endmodule

// File: rtl/omsg_ctrl_regs.sv
module omsg_ctrl_regs
    import omsg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              en,
    output logic [CODE_W-1:0] size_code,
    output logic              adv_req,
    output logic              deq_load,
    output logic              enq_load,
    output logic [AW-1:0]     load_val,
    input  logic [AW-1:0]     deq_ptr,
    input  logic [AW-1:0]     enq_ptr,
    input  logic [SLOT_W-1:0] slot_idx,
    input  logic              empty,
    input  logic              full,
    input  logic              busy,
    input  logic              ovf_evt,
    input  logic              err_evt,
    input  logic              eom_evt,
    output logic              irq
);
    logic    wr_mode, wr_stat;
    logic    st_err, st_ovf, st_eom, st_empty;
    logic    empty_evt;
    logic [DW-1:0] mode_rd, stat_rd;

    always_comb begin
        wr_mode   = reg_we && (reg_addr == RA_MODE);
        wr_stat   = reg_we && (reg_addr == RA_STAT);
        adv_req   = wr_mode && reg_wdata[MB_ADV];
        deq_load  = reg_we && (reg_addr == RA_DEQ);
        enq_load  = reg_we && (reg_addr == RA_ENQ);
        load_val  = AW'(reg_wdata);
        empty_evt = en && empty && !busy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en        <= 1'b0;
            size_code <= '0;
            st_err    <= 1'b0;
            st_ovf    <= 1'b0;
            st_eom    <= 1'b0;
            st_empty  <= 1'b0;
        end else begin
            if (wr_mode) begin
                en        <= reg_wdata[MB_EN];
                size_code <= reg_wdata[MB_CODE +: CODE_W];
            end
            st_err   <= err_evt   | (st_err   & ~(wr_stat & reg_wdata[SB_ERR]));
            st_ovf   <= ovf_evt   | (st_ovf   & ~(wr_stat & reg_wdata[SB_OVF]));
            st_eom   <= eom_evt   | (st_eom   & ~(wr_stat & reg_wdata[SB_EOM]));
            st_empty <= empty_evt | (st_empty & ~(wr_stat & reg_wdata[SB_EMPTY]));
        end
    end

    always_comb begin
        mode_rd                   = '0;
        mode_rd[MB_EN]            = en;
        mode_rd[MB_CODE +: CODE_W] = size_code;
        stat_rd                   = '0;
        stat_rd[SB_ERR]           = st_err;
        stat_rd[SB_OVF]           = st_ovf;
        stat_rd[SB_FULL]          = full;
        stat_rd[SB_BUSY]          = busy;
        stat_rd[SB_EOM]           = st_eom;
        stat_rd[SB_EMPTY]         = st_empty;
        case (reg_addr)
            RA_MODE: reg_rdata = mode_rd;
            RA_STAT: reg_rdata = stat_rd;
            RA_DEQ:  reg_rdata = DW'(deq_ptr);
            RA_ENQ:  reg_rdata = DW'(enq_ptr);
            RA_SLOT: reg_rdata = DW'(slot_idx);
            default: reg_rdata = '0;
        endcase
        irq = st_err | st_ovf | st_eom;
    end

    // R12: the interrupt only rises after an event one cycle earlier
    p_irq_cause_r12: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(err_evt || ovf_evt || eom_evt));

    // R12: write-one-to-clear of overflow takes effect without a new event
    p_ovf_clear_r12: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && reg_wdata[SB_OVF] && !ovf_evt) |=> !st_ovf);
endmodule

// File: rtl/omsg_chain_engine.sv
module omsg_chain_engine
    import omsg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_rd_en,
    output logic [31:0] mem_rd_addr,
    input  logic        mem_rd_valid,
    input  logic [31:0] mem_rd_data,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [15:0] tx_dest_id,
    output logic [1:0]  tx_mbox,
    output logic [31:0] tx_src_addr,
    output logic [31:0] tx_size,
    output logic        irq
);
    logic              en, adv_req, deq_load, enq_load;
    logic [CODE_W-1:0] size_code;
    logic [AW-1:0]     load_val, deq_ptr, enq_ptr;
    logic              empty, full, ovf_evt;
    logic [SLOT_W-1:0] slot_idx;
    logic              deq_step, eom_evt, err_evt, busy;
    desc_t             tx_desc;

    omsg_ctrl_regs u_regs (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .en(en), .size_code(size_code), .adv_req(adv_req),
        .deq_load(deq_load), .enq_load(enq_load), .load_val(load_val),
        .deq_ptr(deq_ptr), .enq_ptr(enq_ptr), .slot_idx(slot_idx),
        .empty(empty), .full(full), .busy(busy),
        .ovf_evt(ovf_evt), .err_evt(err_evt), .eom_evt(eom_evt),
        .irq(irq)
    );

    omsg_ring_ptrs u_ptrs (
        .clk(clk), .rst(rst),
        .size_code(size_code), .deq_load(deq_load), .enq_load(enq_load),
        .load_val(load_val), .adv_req(adv_req), .deq_step(deq_step),
        .deq_ptr(deq_ptr), .enq_ptr(enq_ptr),
        .empty(empty), .full(full), .ovf_evt(ovf_evt), .slot_idx(slot_idx)
    );

    omsg_desc_fetch u_fetch (
        .clk(clk), .rst(rst),
        .en(en), .empty(empty), .deq_ptr(deq_ptr),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_desc(tx_desc),
        .deq_step(deq_step), .eom_evt(eom_evt), .err_evt(err_evt), .busy(busy)
    );

    always_comb begin
        tx_dest_id  = tx_desc.dest;
        tx_mbox     = tx_desc.mbox;
        tx_src_addr = tx_desc.src;
        tx_size     = tx_desc.count;
    end

    // R7: an accepted request is followed by a dequeue step
    p_accept_step_r7: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> deq_step);

    // R11: a disabled idle engine stays idle
    p_disabled_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (!en && !busy && !(reg_we && reg_addr == RA_MODE)) |=> !busy);
endmodule

// File: tb/sim_omsg_chain_engine.sv
module sim_omsg_chain_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [15:0] tx_dest_id;
    logic [1:0]  tx_mbox;
    logic [31:0] tx_src_addr;
    logic [31:0] tx_size;
    logic        irq;

    always #5 clk = ~clk;

    omsg_chain_engine u0 (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_dest_id(tx_dest_id), .tx_mbox(tx_mbox),
        .tx_src_addr(tx_src_addr), .tx_size(tx_size), .irq(irq)
    );

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int tx_seen = 0;
    logic [31:0] mem [0:255];
    logic [31:0] exp_addr [$];
    logic [81:0] exp_tx [$];
    logic        pend = 1'b0;
    logic [31:0] pend_addr = '0;
    logic [31:0] cur_mode = '0;
    logic [31:0] v;

    localparam logic [31:0] BASE = 32'h1000;

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int widx(input logic [31:0] a);
        logic [31:0] o;
        o = (a - BASE) >> 2;
        return int'(o[7:0]);
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_desc(input logic [31:0] sa, input logic [31:0] src,
                            input logic [15:0] dest, input logic [1:0] mb,
                            input bit eom, input logic [31:0] cnt);
        for (int i = 0; i < 8; i++) mem[widx(sa) + i] = 32'h0;
        mem[widx(sa) + 1] = src;
        mem[widx(sa) + 2] = {dest, 14'h0, mb};
        mem[widx(sa) + 3] = eom ? 32'h2000_0000 : 32'h0;
        mem[widx(sa) + 6] = cnt;
    endtask

    // model: what one submitted descriptor must produce
    task automatic push_desc(input logic [31:0] sa);
        logic [31:0] w2, cnt;
        exp_addr.push_back(sa + 4);
        exp_addr.push_back(sa + 8);
        exp_addr.push_back(sa + 12);
        exp_addr.push_back(sa + 24);
        w2  = mem[widx(sa) + 2];
        cnt = mem[widx(sa) + 6];
        if (cnt != 0 && (cnt & (cnt - 1)) == 0)
            exp_tx.push_back({w2[31:16], w2[1:0], mem[widx(sa) + 1], cnt});
    endtask

    task automatic mui();
        wr(3'd0, cur_mode | 32'h2);
    endtask

    task automatic drain();
        logic [31:0] s, dq, eq;
        bit done;
        done = 0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 400 && !done; i++) begin
            rd(3'd1, s); rd(3'd2, dq); rd(3'd3, eq);
            if (s[2] == 1'b0 && dq == eq) done = 1;
        end
        check_eq("R10", "ring drained", {31'h0, done}, 32'h1);
    endtask

    // memory model, ready pattern and per-cycle comparison
    always @(negedge clk) begin
        cyc++;
        mem_rd_valid = pend;
        mem_rd_data  = pend ? mem[widx(pend_addr)] : 32'h0;
        pend = 1'b0;
        tx_ready = (cyc % 3) != 0;
        if (!rst && mem_rd_en) begin
            pend = 1'b1;
            pend_addr = mem_rd_addr;
            if (exp_addr.size() == 0) check_eq("R5", "unexpected read", mem_rd_addr, 32'hFFFF_FFFF);
            else check_eq("R5", "read address", mem_rd_addr, exp_addr.pop_front());
        end
        if (!rst && tx_valid && tx_ready) begin
            tx_seen++;
            if (exp_tx.size() == 0) check_eq("R6", "unexpected request", tx_src_addr, 32'hFFFF_FFFF);
            else check_eq("R6", "request fields", {14'h0, tx_dest_id, tx_mbox} ^ tx_src_addr ^ tx_size,
                          {14'h0, exp_tx[0][81:66], exp_tx[0][65:64]} ^ exp_tx[0][63:32] ^ exp_tx[0][31:0]);
            if (exp_tx.size() != 0) begin
                check_eq("R6", "dest id", {16'h0, tx_dest_id}, {16'h0, exp_tx[0][81:66]});
                check_eq("R6", "size", tx_size, exp_tx[0][31:0]);
                void'(exp_tx.pop_front());
            end
        end
    end

    always @(negedge clk) begin
        if (cyc > 20000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(3'd0, v); check_eq("R1", "mode", v, 32'h0);
        rd(3'd1, v); check_eq("R1", "status", v, 32'h0);
        rd(3'd2, v); check_eq("R1", "dequeue", v, 32'h0);
        check_eq("R1", "irq/valid/rd", {29'h0, irq, tx_valid, mem_rd_en}, 32'h0);

        // ring of 4 slots at BASE, disabled
        cur_mode = 32'h1000;
        wr(3'd2, BASE); wr(3'd3, BASE); wr(3'd0, cur_mode);
        rd(3'd4, v); check_eq("R13", "slot after load", v, 32'h0);
        set_desc(BASE + 32'h00, 32'hA000_0000, 16'h1234, 2'd1, 1, 32'd64);
        set_desc(BASE + 32'h20, 32'hA000_0100, 16'hBEEF, 2'd3, 0, 32'd8);
        set_desc(BASE + 32'h40, 32'hA000_0200, 16'h0042, 2'd2, 1, 32'd24);
        set_desc(BASE + 32'h60, 32'hA000_0300, 16'h7777, 2'd0, 1, 32'd4096);
        for (int s = 0; s < 3; s++) begin
            mui(); push_desc(BASE + 32'(s * 32));
        end
        rd(3'd3, v); check_eq("R2", "enqueue after 3 advances", v, BASE + 32'h60);
        rd(3'd0, v); check_eq("R2", "advance bit reads 0", v, 32'h1000);
        rd(3'd1, v); check_eq("R3", "full bit", {31'h0, v[4]}, 32'h1);
        mui();
        rd(3'd3, v); check_eq("R3", "enqueue held on overflow", v, BASE + 32'h60);
        rd(3'd1, v); check_eq("R3", "overflow bit", {31'h0, v[5]}, 32'h1);
        check_eq("R12", "irq on overflow", {31'h0, irq}, 32'h1);
        check_eq("R11", "disabled engine sent nothing", tx_seen, 0);
        wr(3'd1, 32'h20);
        rd(3'd1, v); check_eq("R12", "overflow cleared", {31'h0, v[5]}, 32'h0);
        check_eq("R12", "irq cleared", {31'h0, irq}, 32'h0);

        // enable: slots 0,1 sent, slot 2 bad count skipped
        cur_mode = 32'h1001;
        wr(3'd0, cur_mode);
        drain();
        rd(3'd2, v); check_eq("R7", "dequeue after 3", v, BASE + 32'h60);
        rd(3'd4, v); check_eq("R7", "slot index", v, 32'd3);
        check_eq("R9", "requests sent", tx_seen, 2);
        rd(3'd1, v);
        check_eq("R9", "error bit", {31'h0, v[7]}, 32'h1);
        check_eq("R8", "eom bit set", {31'h0, v[1]}, 32'h1);
        check_eq("R10", "empty bit", {31'h0, v[0]}, 32'h1);
        wr(3'd1, 32'h83);
        rd(3'd1, v); check_eq("R12", "status after clear", v, 32'h1);
        check_eq("R12", "irq low", {31'h0, irq}, 32'h0);

        // slot 3 without eom request, pointers wrap
        set_desc(BASE + 32'h60, 32'hA000_0300, 16'h7777, 2'd0, 0, 32'd4096);
        mui(); push_desc(BASE + 32'h60);
        drain();
        rd(3'd3, v); check_eq("R2", "enqueue wrap", v, BASE);
        rd(3'd2, v); check_eq("R7", "dequeue wrap", v, BASE);
        check_eq("R6", "request count", tx_seen, 3);
        rd(3'd1, v); check_eq("R8", "eom stays clear", {31'h0, v[1]}, 32'h0);

        // disable mid-descriptor
        set_desc(BASE + 32'h00, 32'hB000_0000, 16'h0A0B, 2'd2, 1, 32'd16);
        set_desc(BASE + 32'h20, 32'hB000_0200, 16'hC0DE, 2'd1, 0, 32'd2);
        mui(); push_desc(BASE);
        mui(); push_desc(BASE + 32'h20);
        cur_mode = 32'h1000;
        wr(3'd0, cur_mode);
        repeat (80) @(negedge clk);
        check_eq("R11", "one request before stop", tx_seen, 4);
        rd(3'd2, v); check_eq("R11", "dequeue kept", v, BASE + 32'h20);
        rd(3'd3, v); check_eq("R11", "enqueue kept", v, BASE + 32'h40);
        rd(3'd1, v); check_eq("R11", "not busy", {31'h0, v[2]}, 32'h0);
        cur_mode = 32'h1001;
        wr(3'd0, cur_mode);
        drain();
        check_eq("R11", "resumed request", tx_seen, 5);
        rd(3'd2, v); check_eq("R11", "dequeue after resume", v, BASE + 32'h40);

        // two-slot ring (code 0)
        cur_mode = 32'h0000;
        wr(3'd0, cur_mode);
        wr(3'd2, BASE + 32'h100); wr(3'd3, BASE + 32'h100);
        rd(3'd4, v); check_eq("R13", "slot after base reload", v, 32'h0);
        mui();
        rd(3'd3, v); check_eq("R4", "one advance fits", v, BASE + 32'h120);
        mui();
        rd(3'd3, v); check_eq("R4", "second advance rejected", v, BASE + 32'h120);
        rd(3'd1, v); check_eq("R4", "overflow on 2-slot ring", {31'h0, v[5]}, 32'h1);

        check_eq("R5", "all reads consumed", exp_addr.size(), 0);
        check_eq("R6", "all requests consumed", exp_tx.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule